// File: doc/BRIEF.md
# Prioritized Refresh and Memory Cycle Arbiter

This block decides which of three clients may run the next cycle on a shared dynamic-RAM row bus: a display fetch unit, a processor port and an on-chip refresh timer. The display and the processor each present an active-low request and receive an active-low acknowledge. Refresh requests come from an internal interval timer that keeps a count of firings not yet served, so a firing is never dropped while the bus is busy.

Arbitration has two levels. Refresh and processor are resolved against each other first, with refresh ahead by default. The display then beats whatever that first level picked. Choosing happens only while the bus is free. A cycle that has started always runs to its end, so a display request that arrives during a processor or refresh cycle waits for that cycle to release.

For every granted cycle the block generates the timing strobes in clock ticks: chip enable, a write-enable pulse for processor writes, a one-tick output-latch strobe for reads, and a one-tick end-of-cycle pulse when the bus is released. A precharge gap enforces the minimum spacing between chip-enable rises. It also steers the row-address multiplexer. During a refresh cycle the refresh row counter drives the row bits and the external address buffer is disabled. During display and processor cycles the external row address is passed through.

Top module: `dram_cycle_arbiter`

## Requirements
- R1: At most one of `disp_ack_n`, `cpu_ack_n`, `ref_ack_n` is low in any clock cycle. An acknowledge is low from the tick after its grant until the release tick. All three are high in the idle tick that follows each release.
- R2: When the bus is free and a display request is pending, the display is granted, whatever processor or refresh requests are pending at the same time.
- R3: When the bus is free, no display request is pending, and both a processor request and a refresh firing are pending, refresh is granted first (parameter `REF_FIRST`=1).
- R4: A granted cycle is never pre-empted. A request that arrives while a cycle runs is considered only after that cycle's release.
- R5: The refresh timer fires once every `REF_INTERVAL` ticks and adds one to a pending count. Each completed refresh cycle removes one pending firing and advances the row counter `ref_row` by one, modulo 64 (0,1,...,63,0). It starts at 0 after reset. Under periodic display traffic, any window of 64 firing intervals contains refresh cycles for all 64 rows.
- R6: During a refresh grant, `row_addr` equals `ref_row` and `ext_buf_en` is 0. During a display or processor grant, `row_addr` equals `ext_row` and `ext_buf_en` is 1.
- R7: `mem_ce` rises on the first tick of a cycle and stays high for `REL_TICKS` (25) ticks. On the tick where it falls, `cyc_end` is high for one tick and the acknowledge is released.
- R8: In display cycles and processor read cycles, `latch_stb` is high for exactly one tick, at offset `LATCH_AT` (18) ticks after `mem_ce` rises. It is never high in refresh or processor write cycles.
- R9: In a processor write cycle (`cpu_wr`=1 when granted), `mem_we_n` is low for `WE_LEN` (5) ticks starting at offset `WE_AT` (10) ticks after `mem_ce` rises. In all other cycles `mem_we_n` stays high.
- R10: Two successive rising edges of `mem_ce` are at least `CYC_TICKS` (40) ticks apart.
- R11: In a display cycle, holding `disp_hold_n` low keeps `mem_ce` high past `REL_TICKS`, until `disp_hold_n` returns high.
- R12: After reset, all acknowledges are high, `mem_ce`, `latch_stb`, `cyc_end` and `ext_buf_en` are 0, `mem_we_n` is 1, and `ref_row` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick is the timing unit |
| rst | input | 1 | Synchronous active-high reset |
| disp_req_n | input | 1 | Display request, active low |
| disp_hold_n | input | 1 | Display hold; low keeps a display cycle's chip enable on |
| cpu_req_n | input | 1 | Processor request, active low |
| cpu_wr | input | 1 | Processor access is a write when 1 (sampled at grant) |
| ext_row | input | ROW_W | Row address from the display/processor path |
| disp_ack_n | output | 1 | Display acknowledge, active low |
| cpu_ack_n | output | 1 | Processor acknowledge, active low |
| ref_ack_n | output | 1 | Refresh acknowledge, active low |
| row_addr | output | ROW_W | Row-select bits sent to the RAM array |
| ext_buf_en | output | 1 | Enables the display/processor address buffer |
| ref_row | output | ROW_W | Current refresh row counter |
| mem_ce | output | 1 | Chip enable |
| mem_we_n | output | 1 | Write enable, active low |
| latch_stb | output | 1 | Output data latch strobe |
| cyc_end | output | 1 | One-tick pulse at cycle release |

## Verification
The hard coincidence is a release tick that finds a display request, a processor request and an unserved refresh firing all pending at once. Both arbitration levels have to be resolved in that one idle tick. The bench provokes this by stretching a display cycle with the hold input across a timer firing, while it posts a processor request and a fresh display request. It then judges the order of the next three grants: display, refresh, processor. Separately, periodic display traffic runs for two full sets of refresh intervals, and the bench counts refresh cycles per window and checks that the refreshed rows step without gaps.

// File: rtl/dcarb_pkg.sv
package dcarb_pkg;

    // Who owns the row bus
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_DISP = 2'd1,
        OWN_CPU  = 2'd2,
        OWN_REF  = 2'd3
    } owner_e;

    // Sequencer phase
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_ACT  = 2'd2
    } phase_e;

    // Active-high view of the three request sources
    typedef struct packed {
        logic disp;
        logic cpu;
        logic refr;
    } req_s;

    // Second level: display beats whatever the first level chose
    function automatic owner_e top_pick(input logic disp, input owner_e lvl1);
        return disp ? OWN_DISP : lvl1;
    endfunction

endpackage

// File: rtl/dcarb_refresh_timer.sv
module dcarb_refresh_timer
    import dcarb_pkg::*;
#(
    parameter int INTERVAL = 3125,
    parameter int ROW_W    = 6,
    parameter int PEND_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             served,
    output logic             ref_req,
    output logic [ROW_W-1:0] row
);
    localparam int TCNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(INTERVAL - 1);
    localparam logic [PEND_W-1:0] PEND_MAX  = {PEND_W{1'b1}};

    logic [TCNT_W-1:0] tcnt;
    logic [PEND_W-1:0] pend;
    logic              fire;

    assign fire    = (tcnt == TCNT_LAST);
    assign ref_req = (pend != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
        end else if (fire) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Pending firings: a firing is kept until a refresh cycle retires it (R5)
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            unique case ({fire, served})
                2'b10:   if (pend != PEND_MAX) pend <= pend + 1'b1;
                2'b01:   pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (served) begin
            row <= row + 1'b1;
        end
    end

endmodule

// File: rtl/dcarb_resolver.sv
module dcarb_resolver
    import dcarb_pkg::*;
#(
    parameter bit REF_FIRST = 1'b1
) (
    input  req_s   req,
    output owner_e win
);
    owner_e lvl1;

    // First level: refresh against processor, order picked by parameter (R3)
    generate
        if (REF_FIRST) begin : g_ref_first
            assign lvl1 = req.refr ? OWN_REF : (req.cpu ? OWN_CPU : OWN_NONE);
        end else begin : g_cpu_first
            assign lvl1 = req.cpu ? OWN_CPU : (req.refr ? OWN_REF : OWN_NONE);
        end
    endgenerate

    // Second level: display over the first-level result (R2)
    assign win = top_pick(req.disp, lvl1);

endmodule

// File: rtl/dcarb_cycle_seq.sv
module dcarb_cycle_seq
    import dcarb_pkg::*;
#(
    parameter int REL_TICKS = 25,
    parameter int CYC_TICKS = 40,
    parameter int WE_AT     = 10,
    parameter int WE_LEN    = 5,
    parameter int LATCH_AT  = 18
) (
    input  logic   clk,
    input  logic   rst,
    input  owner_e win,
    input  logic   cpu_wr,
    input  logic   disp_hold_n,
    output owner_e owner,
    output logic   ce,
    output logic   we_n,
    output logic   latch_stb,
    output logic   cyc_end,
    output logic   ref_served
);
    localparam int CNT_W = $clog2(REL_TICKS + 1);
    localparam int GAP_W = $clog2(CYC_TICKS - REL_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(REL_TICKS - 1);
    localparam logic [CNT_W-1:0] WE_FIRST  = CNT_W'(WE_AT);
    localparam logic [CNT_W-1:0] WE_STOP   = CNT_W'(WE_AT + WE_LEN);
    localparam logic [CNT_W-1:0] LATCH_PT  = CNT_W'(LATCH_AT);
    localparam logic [GAP_W-1:0] GAP_LOAD  = GAP_W'(CYC_TICKS - REL_TICKS - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic [GAP_W-1:0] gap;
    logic             wr_q;
    logic             end_q;
    logic             at_last;
    logic             stretch;

    assign at_last = (phase == PH_ACT) && (cnt == CNT_LAST);
    // Only a display cycle may be stretched (R11)
    assign stretch = (owner == OWN_DISP) && !disp_hold_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            owner <= OWN_NONE;
            cnt   <= '0;
            gap   <= '0;
            wr_q  <= 1'b0;
            end_q <= 1'b0;
        end else begin
            end_q <= 1'b0;
            if (gap != '0) gap <= gap - 1'b1;
            unique case (phase)
                PH_IDLE: begin
                    // Grants are made only while the bus is free (R4)
                    if (win != OWN_NONE) begin
                        owner <= win;
                        wr_q  <= cpu_wr && (win == OWN_CPU);
                        cnt   <= '0;
                        phase <= (gap == '0) ? PH_ACT : PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    // Precharge gap keeps chip-enable rises apart (R10)
                    if (gap == '0) begin
                        phase <= PH_ACT;
                        cnt   <= '0;
                    end
                end
                PH_ACT: begin
                    if (at_last) begin
                        if (!stretch) begin
                            phase <= PH_IDLE;
                            owner <= OWN_NONE;
                            wr_q  <= 1'b0;
                            end_q <= 1'b1;
                            gap   <= GAP_LOAD;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign ce         = (phase == PH_ACT);
    assign we_n       = !(ce && wr_q && (cnt >= WE_FIRST) && (cnt < WE_STOP));
    assign latch_stb  = ce && !wr_q && (owner != OWN_REF) && (cnt == LATCH_PT);
    assign cyc_end    = end_q;
    assign ref_served = at_last && (owner == OWN_REF);

endmodule

// File: rtl/dram_cycle_arbiter.sv
module dram_cycle_arbiter
    import dcarb_pkg::*;
#(
    parameter int ROW_W        = 6,
    parameter int REF_INTERVAL = 3125,
    parameter int PEND_W       = 3,
    parameter int REL_TICKS    = 25,
    parameter int CYC_TICKS    = 40,
    parameter int WE_AT        = 10,
    parameter int WE_LEN       = 5,
    parameter int LATCH_AT     = 18,
    parameter bit REF_FIRST    = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disp_req_n,
    input  logic             disp_hold_n,
    input  logic             cpu_req_n,
    input  logic             cpu_wr,
    input  logic [ROW_W-1:0] ext_row,
    output logic             disp_ack_n,
    output logic             cpu_ack_n,
    output logic             ref_ack_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             ext_buf_en,
    output logic [ROW_W-1:0] ref_row,
    output logic             mem_ce,
    output logic             mem_we_n,
    output logic             latch_stb,
    output logic             cyc_end
);
    req_s   req;
    owner_e win;
    owner_e owner;
    logic   ref_req;
    logic   ref_served;

    dcarb_refresh_timer #(
        .INTERVAL (REF_INTERVAL),
        .ROW_W    (ROW_W),
        .PEND_W   (PEND_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .served  (ref_served),
        .ref_req (ref_req),
        .row     (ref_row)
    );

    assign req.disp = !disp_req_n;
    assign req.cpu  = !cpu_req_n;
    assign req.refr = ref_req;

    dcarb_resolver #(
        .REF_FIRST (REF_FIRST)
    ) u_resolver (
        .req (req),
        .win (win)
    );

    dcarb_cycle_seq #(
        .REL_TICKS (REL_TICKS),
        .CYC_TICKS (CYC_TICKS),
        .WE_AT     (WE_AT),
        .WE_LEN    (WE_LEN),
        .LATCH_AT  (LATCH_AT)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .win         (win),
        .cpu_wr      (cpu_wr),
        .disp_hold_n (disp_hold_n),
        .owner       (owner),
        .ce          (mem_ce),
        .we_n        (mem_we_n),
        .latch_stb   (latch_stb),
        .cyc_end     (cyc_end),
        .ref_served  (ref_served)
    );

    // One acknowledge per owner code (R1)
    assign disp_ack_n = (owner != OWN_DISP);
    assign cpu_ack_n  = (owner != OWN_CPU);
    assign ref_ack_n  = (owner != OWN_REF);

    // Row multiplexer: refresh counter alone during refresh (R6)
    assign ext_buf_en = (owner == OWN_DISP) || (owner == OWN_CPU);
    assign row_addr   = (owner == OWN_REF) ? ref_row : ext_row;

endmodule

// File: rtl/dcarb_checker.sv
module dcarb_checker #(
    parameter int ROW_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             disp_ack_n,
    input logic             cpu_ack_n,
    input logic             ref_ack_n,
    input logic [ROW_W-1:0] row_addr,
    input logic             ext_buf_en,
    input logic [ROW_W-1:0] ref_row,
    input logic             mem_ce,
    input logic             mem_we_n,
    input logic             latch_stb,
    input logic             cyc_end
);
    AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
        $countones({~disp_ack_n, ~cpu_ack_n, ~ref_ack_n}) <= 1); // R1

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (mem_ce && $past(mem_ce)) |-> $stable({disp_ack_n, cpu_ack_n, ref_ack_n})); // R4

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_row) |-> (cyc_end && (ROW_W'(ref_row - $past(ref_row)) == ROW_W'(1)))); // R5

    AST_REF_ROW_SRC: assert property (@(posedge clk) disable iff (rst)
        !ref_ack_n |-> ((row_addr == ref_row) && !ext_buf_en)); // R6

    AST_CE_OWNED: assert property (@(posedge clk) disable iff (rst)
        mem_ce |-> !(disp_ack_n && cpu_ack_n && ref_ack_n)); // R7

    AST_LATCH_READ: assert property (@(posedge clk) disable iff (rst)
        latch_stb |-> (mem_ce && mem_we_n && ref_ack_n)); // R8

    AST_WE_CPU_ONLY: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_ce && !cpu_ack_n)); // R9

endmodule

bind dram_cycle_arbiter dcarb_checker #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_ack_n (disp_ack_n),
    .cpu_ack_n  (cpu_ack_n),
    .ref_ack_n  (ref_ack_n),
    .row_addr   (row_addr),
    .ext_buf_en (ext_buf_en),
    .ref_row    (ref_row),
    .mem_ce     (mem_ce),
    .mem_we_n   (mem_we_n),
    .latch_stb  (latch_stb),
    .cyc_end    (cyc_end)
);

// File: tb/test_dram_cycle_arbiter.sv
module test_dram_cycle_arbiter;
    localparam int CLK_NS   = 10;
    localparam int ROW_W    = 6;
    localparam int INTERVAL = 500;
    localparam int REL      = 25;
    localparam int CYC      = 40;
    localparam int WINDOW   = 64 * INTERVAL + 200;
    localparam int VEC_N    = 5;
    // fields: disp, cpu, wr, owner[1:0] (1 disp, 2 cpu, 3 refresh), we expected, latch expected
    localparam logic [6:0] VEC [VEC_N] = '{
        7'b1_0_0_01_0_1,
        7'b0_1_0_10_0_1,
        7'b0_1_1_10_1_0,
        7'b1_1_0_01_0_1,
        7'b1_1_1_01_0_1
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic disp_hold_n = 1'b1;
    logic cpu_wr = 1'b0;
    logic [ROW_W-1:0] ext_row = 6'h15;
    logic disp_req_n, cpu_req_n;
    logic disp_ack_n, cpu_ack_n, ref_ack_n, ext_buf_en, mem_ce, mem_we_n, latch_stb, cyc_end;
    logic [ROW_W-1:0] row_addr, ref_row;

    always #(CLK_NS/2) clk = ~clk;

    dram_cycle_arbiter #(.ROW_W(ROW_W), .REF_INTERVAL(INTERVAL)) i_dram_cycle_arbiter (
        .clk(clk), .rst(rst), .disp_req_n(disp_req_n), .disp_hold_n(disp_hold_n),
        .cpu_req_n(cpu_req_n), .cpu_wr(cpu_wr), .ext_row(ext_row),
        .disp_ack_n(disp_ack_n), .cpu_ack_n(cpu_ack_n), .ref_ack_n(ref_ack_n),
        .row_addr(row_addr), .ext_buf_en(ext_buf_en), .ref_row(ref_row),
        .mem_ce(mem_ce), .mem_we_n(mem_we_n), .latch_stb(latch_stb), .cyc_end(cyc_end));

    int n_checks = 0, n_fails = 0;
    bit done = 0;

    // Requesters: a request stays low until its acknowledge is seen
    int disp_asks = 0, disp_grants = 0, cpu_asks = 0, cpu_grants = 0;
    logic disp_seen = 1'b0, cpu_seen = 1'b0;
    assign disp_req_n = (disp_asks == disp_grants);
    assign cpu_req_n  = (cpu_asks == cpu_grants);

    // Monitor state
    int tk = 0, ce_start = -1000, prev_start = -1000;
    int cur_owner = 0, we_off = -1, we_len = 0, lat_off = -1, lat_cnt = 0;
    int last_owner = 0, last_len = 0, last_we_off = -1, last_we_len = 0, last_lat_off = -1, last_lat_cnt = 0;
    int cyc_cnt = 0, ref_seen = 0, disp_seen_cyc = 0, exp_row = 0;
    int ack_viol = 0, sp_viol = 0, ref_bad = 0, addr_bad = 0, end_bad = 0;
    int owner_log [64];
    int len_log [64];
    logic prev_ce = 1'b0;

    always @(negedge clk) begin
        tk = tk + 1;
        if (!disp_ack_n && !disp_seen) disp_grants = disp_grants + 1;
        if (!cpu_ack_n && !cpu_seen) cpu_grants = cpu_grants + 1;
        disp_seen = !disp_ack_n;
        cpu_seen  = !cpu_ack_n;
        if (!rst) begin
            if ((!disp_ack_n + !cpu_ack_n + !ref_ack_n) > 1) ack_viol = ack_viol + 1;
            if (mem_ce && !prev_ce) begin
                ce_start = tk;
                if (tk - prev_start < CYC) sp_viol = sp_viol + 1;
                prev_start = tk;
                cur_owner = !disp_ack_n ? 1 : (!cpu_ack_n ? 2 : (!ref_ack_n ? 3 : 0));
                we_off = -1; we_len = 0; lat_off = -1; lat_cnt = 0;
                if (cur_owner == 3) begin
                    if (row_addr != ROW_W'(exp_row) || ext_buf_en) ref_bad = ref_bad + 1;
                    exp_row = (exp_row + 1) % 64;
                    ref_seen = ref_seen + 1;
                end else begin
                    if (row_addr != ext_row || !ext_buf_en) addr_bad = addr_bad + 1;
                    if (cur_owner == 1) disp_seen_cyc = disp_seen_cyc + 1;
                end
            end
            if (mem_ce && !mem_we_n) begin
                if (we_off < 0) we_off = tk - ce_start;
                we_len = we_len + 1;
            end
            if (latch_stb) begin
                lat_off = tk - ce_start;
                lat_cnt = lat_cnt + 1;
            end
            if (!mem_ce && prev_ce) begin
                if (!cyc_end || !(disp_ack_n && cpu_ack_n && ref_ack_n)) end_bad = end_bad + 1;
                last_owner = cur_owner; last_len = tk - ce_start;
                last_we_off = we_off; last_we_len = we_len;
                last_lat_off = lat_off; last_lat_cnt = lat_cnt;
                owner_log[cyc_cnt % 64] = cur_owner;
                len_log[cyc_cnt % 64] = tk - ce_start;
                cyc_cnt = cyc_cnt + 1;
            end
            prev_ce = mem_ce;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int target);
        while (cyc_cnt < target) @(negedge clk);
    endtask

    task automatic wait_ref_clear();
        while (ref_ack_n) @(negedge clk);
        while (!ref_ack_n) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks = n_checks + 1;
        n_fails = n_fails + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", tk, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R12: reset state
        chk(disp_ack_n && cpu_ack_n && ref_ack_n, "R12 acks", {disp_ack_n, cpu_ack_n, ref_ack_n}, 7);
        chk(!mem_ce && mem_we_n && !latch_stb && !cyc_end && !ext_buf_en, "R12 strobes",
            {mem_ce, mem_we_n, latch_stb, cyc_end, ext_buf_en}, 8);
        chk(ref_row == 0, "R12 ref_row", ref_row, 0);
        rst = 1'b0;

        // First refresh cycle: row 0, no latch, no write strobe
        wait_ref_clear();
        chk(last_owner == 3, "R5 first refresh", last_owner, 3);
        chk(last_len == REL, "R7 refresh ce length", last_len, REL);
        chk(last_lat_cnt == 0 && last_we_len == 0, "R8 refresh no latch/we", last_lat_cnt + last_we_len, 0);
        chk(ref_row == 1, "R5 row advance", ref_row, 1);

        // Vector table walk
        for (int v = 0; v < VEC_N; v++) begin
            int base;
            wait_ref_clear();
            base = cyc_cnt;
            cpu_wr = VEC[v][4];
            if (VEC[v][6]) disp_asks = disp_asks + 1;
            if (VEC[v][5]) cpu_asks = cpu_asks + 1;
            wait_cycles(base + 1);
            chk(last_owner == int'(VEC[v][3:2]), "R2 winner", last_owner, int'(VEC[v][3:2]));
            chk(last_len == REL, "R7 ce length", last_len, REL);
            if (VEC[v][1]) chk(last_we_off == 10 && last_we_len == 5, "R9 we window", last_we_off * 100 + last_we_len, 1005);
            else           chk(last_we_len == 0, "R9 no we", last_we_len, 0);
            if (VEC[v][0]) chk(last_lat_off == 18 && last_lat_cnt == 1, "R8 latch", last_lat_off * 100 + last_lat_cnt, 1801);
            else           chk(last_lat_cnt == 0, "R8 no latch", last_lat_cnt, 0);
            if (VEC[v][6] && VEC[v][5]) begin
                wait_cycles(base + 2);
                chk(last_owner == 2, "R4 cpu served after display", last_owner, 2);
                chk(last_we_len == (VEC[v][4] ? 5 : 0), "R9 second cycle we", last_we_len, VEC[v][4] ? 5 : 0);
            end
        end

        // Held display cycle spanning a refresh firing, then a three-way contest
        begin
            int base;
            wait_ref_clear();
            cpu_wr = 1'b0;
            disp_hold_n = 1'b0;
            base = cyc_cnt;
            disp_asks = disp_asks + 1;
            while (!mem_ce) @(negedge clk);
            repeat (100) @(negedge clk);
            cpu_asks = cpu_asks + 1;
            disp_asks = disp_asks + 1;
            repeat (500) @(negedge clk);
            chk(mem_ce && !disp_ack_n, "R11 ce held", mem_ce, 1);
            chk(cpu_ack_n, "R4 cpu waits during display", cpu_ack_n, 1);
            disp_hold_n = 1'b1;
            wait_cycles(base + 4);
            chk(len_log[base % 64] > REL, "R11 stretched length", len_log[base % 64], REL + 1);
            chk(owner_log[(base + 1) % 64] == 1, "R2 display beats refresh and cpu", owner_log[(base + 1) % 64], 1);
            chk(owner_log[(base + 2) % 64] == 3, "R3 refresh beats cpu", owner_log[(base + 2) % 64], 3);
            chk(owner_log[(base + 3) % 64] == 2, "R4 cpu last", owner_log[(base + 3) % 64], 2);
        end

        // Periodic display traffic across two refresh windows
        begin
            int s0 = -1, t0 = 0, disp0;
            disp0 = disp_seen_cyc;
            for (int i = 0; i < 2 * WINDOW; i++) begin
                @(negedge clk);
                if ((i % 64) == 0 && disp_req_n) disp_asks = disp_asks + 1;
                if (s0 < 0 && i > 200 && !ref_ack_n && mem_ce) begin
                    s0 = ref_seen; t0 = i;
                end
                if (s0 >= 0 && i == t0 + WINDOW) begin
                    chk((ref_seen - s0 + 1) >= 64 && (ref_seen - s0 + 1) <= 66,
                        "R5 all rows per window", ref_seen - s0 + 1, 64);
                end
            end
            chk(disp_seen_cyc - disp0 > 1000, "R5 display traffic ran", disp_seen_cyc - disp0, 1000);
        end

        repeat (100) @(negedge clk);
        chk(ack_viol == 0, "R1 single acknowledge", ack_viol, 0);
        chk(sp_viol == 0, "R10 ce spacing", sp_viol, 0);
        chk(ref_bad == 0, "R6 refresh row source", ref_bad, 0);
        chk(addr_bad == 0, "R6 external row source", addr_bad, 0);
        chk(end_bad == 0, "R7 cyc_end at release", end_bad, 0);
        finish_run();
    end
endmodule